// File: doc/BRIEF.md
# Wide Access Byte Splitter

This block sits between a host request port and a peripheral that can only move one byte per bus cycle. The host asks for an 8-, 16- or 32-bit read or write and says per request whether the data is big-endian or little-endian. The splitter turns that one request into the right number of byte cycles on the peripheral side, all aimed at the same address. For writes it picks each byte out of the data word in the order the endianness asks for. For reads it collects the returned bytes into a right-aligned word.

The peripheral returns each read byte in the upper half of a 16-bit bus word, and the splitter takes the byte from there. Only one request is in flight at a time. A single-cycle completion pulse ends each request and carries the assembled read data. Address translation and the electrical form of the peripheral bus are handled elsewhere.

Top module: `wide_access_splitter`

## Requirements
- R1: The size code `req_size` picks the number of byte cycles. Code 0 gives one byte cycle, code 1 gives two and code 2 gives four. Code 3 is treated like code 2 and gives four.
- R2: In a big-endian write, the byte cycles carry the bytes of the low 1, 2 or 4 bytes of `req_wdata` from the most significant byte down to the least significant. With 4 bytes, the first byte cycle carries bits 31:24 and the last carries bits 7:0.
- R3: In a little-endian write, the byte cycles carry those same bytes from the least significant up to the most significant. The first byte cycle carries bits 7:0.
- R4: Every byte cycle of a request presents the address that was accepted with that request. The address is not incremented between byte cycles.
- R5: Each read byte is taken from bits 15:8 of `bc_rword` in the cycle where `bc_done` is high. Bits 7:0 of `bc_rword` have no effect on the result.
- R6: In a big-endian read, the first returned byte lands in the most significant byte of the access width. In a little-endian read, the first returned byte lands in bits 7:0. The result is right-aligned, and all bits above the access width read as zero.
- R7: `req_ready` is high only when the splitter is idle. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high, and the first byte cycle follows on the next cycle. `rsp_done` goes high for exactly one cycle, in the cycle after the edge that completes the last byte. `rsp_rdata` holds the read result at that time, and it is zero for a write.
- R8: A byte cycle keeps `bc_valid`, `bc_addr` and `bc_wbyte` steady until `bc_done` is seen. `bc_write` equals the write flag of the request.
- R9: A synchronous reset makes the splitter idle: `req_ready` high, `bc_valid` and `rsp_done` low. It also discards any read bytes gathered so far, so none of them leak into a later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Splitter idle, will accept a request |
| req_addr | input | ADDR_W | Peripheral address for all byte cycles |
| req_size | input | SIZE_W | Access size code (0: 1 byte, 1: 2 bytes, 2 or 3: 4 bytes) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_big_end | input | 1 | 1 = big-endian byte order, 0 = little-endian |
| req_wdata | input | DATA_W | Write data, right-aligned |
| bc_valid | output | 1 | Byte cycle requested |
| bc_addr | output | ADDR_W | Byte cycle address |
| bc_write | output | 1 | Byte cycle direction |
| bc_wbyte | output | 8 | Byte to write |
| bc_rword | input | 16 | Peripheral read word, data byte in bits 15:8 |
| bc_done | input | 1 | Peripheral finished the current byte cycle |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Assembled read data, valid with rsp_done |

## Verification
The assertions assume that the host holds `req_valid` low once a request has been taken, until `req_ready` comes back. They also assume that the peripheral raises `bc_done` only while `bc_valid` is high and holds it for a single cycle per byte. The directed tasks drop `req_valid` right after the acceptance edge. The bench's peripheral model pulses `bc_done` once per observed byte cycle, after a chosen wait. The model also sets the low half of `bc_rword` to a changing junk value, so that any use of those bits shows up in the result.

// File: rtl/splitter_pkg.sv
package splitter_pkg;

    // Sequencer phases: waiting for a host request, or walking byte cycles.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_phase_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/splitter_size_dec.sv
// Maps the host size code to the index of the last byte cycle.
module splitter_size_dec #(
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned SIZE_W = 2
) (
    input  logic [SIZE_W-1:0] size_code,
    output logic [IDX_W-1:0]  last_idx
);

    always_comb begin
        // Codes at or beyond the widest width clamp to the full word.
        last_idx = '1;
        for (int s = 0; s < int'(IDX_W); s++) begin
            if (size_code == SIZE_W'(s)) begin
                last_idx = IDX_W'((1 << s) - 1);
            end
        end
    end

endmodule

// File: rtl/splitter_lane_sel.sv
// Picks the byte lane that the current byte cycle uses.
module splitter_lane_sel #(
    parameter int unsigned IDX_W = 2
) (
    input  logic [IDX_W-1:0] last_idx,
    input  logic [IDX_W-1:0] beat_idx,
    input  logic             big_end,
    output logic [IDX_W-1:0] lane
);

    // Big-endian walks down from the top lane of the access width,
    // little-endian walks up from lane zero.
    always_comb begin
        if (big_end) begin
            lane = last_idx - beat_idx;
        end else begin
            lane = beat_idx;
        end
    end

endmodule

// File: rtl/splitter_byte_mux.sv
// Extracts one whole byte lane of the held write word.
module splitter_byte_mux #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 2
) (
    input  logic [DATA_W-1:0] word,
    input  logic [IDX_W-1:0]  lane,
    output logic [7:0]        byte_out
);

    localparam int unsigned LANES = DATA_W / splitter_pkg::BYTE_W;

    logic [7:0] lane_bytes [LANES];

    for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
        assign lane_bytes[g] = word[g*8 +: 8];
    end

    assign byte_out = lane_bytes[lane];

endmodule

// File: rtl/splitter_read_merge.sv
// ORs a returned byte into the accumulator at the selected lane.
module splitter_read_merge #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 2
) (
    input  logic [DATA_W-1:0] acc_in,
    input  logic [7:0]        byte_in,
    input  logic [IDX_W-1:0]  lane,
    output logic [DATA_W-1:0] acc_out
);

    localparam int unsigned LANES = DATA_W / splitter_pkg::BYTE_W;

    logic [DATA_W-1:0] placed;

    for (genvar g = 0; g < int'(LANES); g++) begin : g_place
        assign placed[g*8 +: 8] = (lane == IDX_W'(g)) ? byte_in : 8'h00;
    end

    assign acc_out = acc_in | placed;

endmodule

// File: rtl/wide_access_splitter.sv
// Splits 8/16/32-bit host accesses into ordered byte cycles.
module wide_access_splitter #(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = $clog2(DATA_W / 8),
    parameter int unsigned SIZE_W = $clog2(IDX_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic              req_write,
    input  logic              req_big_end,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              bc_valid,
    output logic [ADDR_W-1:0] bc_addr,
    output logic              bc_write,
    output logic [7:0]        bc_wbyte,
    input  logic [15:0]       bc_rword,
    input  logic              bc_done,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata
);

    import splitter_pkg::*;

    localparam int unsigned RD_LSB = 8;   // read byte sits in the upper half

    typedef struct packed {
        seq_phase_e        phase;
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic              big_end;
        logic [DATA_W-1:0] wdata;
        logic [IDX_W-1:0]  last_idx;
        logic [IDX_W-1:0]  beat_idx;
        logic [DATA_W-1:0] acc;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [IDX_W-1:0]  req_last_idx;
    logic [IDX_W-1:0]  cur_lane;
    logic [DATA_W-1:0] merged;
    logic [7:0]        rd_byte;

    splitter_size_dec #(
        .IDX_W  (IDX_W),
        .SIZE_W (SIZE_W)
    ) size_dec_i (
        .size_code (req_size),
        .last_idx  (req_last_idx)
    );

    splitter_lane_sel #(
        .IDX_W (IDX_W)
    ) lane_sel_i (
        .last_idx (seq_q.last_idx),
        .beat_idx (seq_q.beat_idx),
        .big_end  (seq_q.big_end),
        .lane     (cur_lane)
    );

    splitter_byte_mux #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) byte_mux_i (
        .word     (seq_q.wdata),
        .lane     (cur_lane),
        .byte_out (bc_wbyte)
    );

    assign rd_byte = bc_rword[RD_LSB +: 8];

    splitter_read_merge #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) read_merge_i (
        .acc_in  (seq_q.acc),
        .byte_in (rd_byte),
        .lane    (cur_lane),
        .acc_out (merged)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.phase)
            SEQ_IDLE: begin
                if (req_valid) begin
                    seq_d.phase    = SEQ_BUSY;
                    seq_d.addr     = req_addr;
                    seq_d.write    = req_write;
                    seq_d.big_end  = req_big_end;
                    seq_d.wdata    = req_wdata;
                    seq_d.last_idx = req_last_idx;
                    seq_d.beat_idx = '0;
                    seq_d.acc      = '0;
                end
            end
            SEQ_BUSY: begin
                if (bc_done) begin
                    if (!seq_q.write) begin
                        seq_d.acc = merged;
                    end
                    if (seq_q.beat_idx == seq_q.last_idx) begin
                        seq_d.phase = SEQ_IDLE;
                        seq_d.done  = 1'b1;
                        seq_d.rdata = seq_q.write ? '0 : merged;
                    end else begin
                        seq_d.beat_idx = seq_q.beat_idx + 1'b1;
                    end
                end
            end
            default: seq_d.phase = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = (seq_q.phase == SEQ_IDLE);
    assign bc_valid  = (seq_q.phase == SEQ_BUSY);
    assign bc_addr   = seq_q.addr;
    assign bc_write  = seq_q.write;
    assign rsp_done  = seq_q.done;
    assign rsp_rdata = seq_q.rdata;

endmodule

// File: rtl/wide_access_splitter_chk.sv
// Protocol checker, bound into every instance of the splitter.
module wide_access_splitter_chk #(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = $clog2(DATA_W / 8),
    parameter int unsigned SIZE_W = $clog2(IDX_W + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [SIZE_W-1:0] req_size,
    input logic              bc_valid,
    input logic [ADDR_W-1:0] bc_addr,
    input logic [7:0]        bc_wbyte,
    input logic              bc_done,
    input logic              rsp_done
);

    logic [IDX_W:0] beats_seen;
    logic [IDX_W:0] beats_owed;

    always_ff @(posedge clk) begin
        if (rst) begin
            beats_seen <= '0;
            beats_owed <= '0;
        end else if (req_valid && req_ready) begin
            beats_seen <= '0;
            if (req_size >= SIZE_W'(IDX_W)) begin
                beats_owed <= (IDX_W+1)'(DATA_W / 8);
            end else begin
                beats_owed <= (IDX_W+1)'(1) << req_size;
            end
        end else if (bc_valid && bc_done) begin
            beats_seen <= beats_seen + 1'b1;
        end
    end

    // R1: completion arrives after exactly the owed number of bytes
    p_beat_count_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (beats_seen == beats_owed));

    // R4: address holds across consecutive byte cycles
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (bc_valid && $past(bc_valid)) |-> $stable(bc_addr));

    // R8: byte held while the peripheral has not finished it
    p_byte_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (bc_valid && $past(bc_valid) && !$past(bc_done)) |-> $stable(bc_wbyte));

    // R7: accepted request starts a byte cycle at once
    p_accept_start_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (bc_valid && !req_ready));

    // R7: no acceptance while a byte cycle is open
    p_busy_block_r7: assert property (@(posedge clk) disable iff (rst)
        bc_valid |-> !req_ready);

    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    // R9: reset leaves the sequencer idle
    p_reset_idle_r9: assert property (@(posedge clk)
        rst |=> (req_ready && !bc_valid && !rsp_done));

endmodule

bind wide_access_splitter wide_access_splitter_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .SIZE_W (SIZE_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_size  (req_size),
    .bc_valid  (bc_valid),
    .bc_addr   (bc_addr),
    .bc_wbyte  (bc_wbyte),
    .bc_done   (bc_done),
    .rsp_done  (rsp_done)
);

// File: tb/wide_access_splitter_tb_top.sv
`timescale 1ns/1ps
module wide_access_splitter_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [23:0] req_addr;
    logic [1:0]  req_size;
    logic        req_write;
    logic        req_big_end;
    logic [31:0] req_wdata;
    logic        bc_valid;
    logic [23:0] bc_addr;
    logic        bc_write;
    logic [7:0]  bc_wbyte;
    logic [15:0] bc_rword;
    logic        bc_done;
    logic        rsp_done;
    logic [31:0] rsp_rdata;

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    wide_access_splitter dut_i (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .req_size    (req_size),
        .req_write   (req_write),
        .req_big_end (req_big_end),
        .req_wdata   (req_wdata),
        .bc_valid    (bc_valid),
        .bc_addr     (bc_addr),
        .bc_write    (bc_write),
        .bc_wbyte    (bc_wbyte),
        .bc_rword    (bc_rword),
        .bc_done     (bc_done),
        .rsp_done    (rsp_done),
        .rsp_rdata   (rsp_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One host access with a peripheral model; rb holds the bytes the
    // peripheral returns, first byte in bits 7:0.
    task automatic run_access(input logic [1:0] sz, input bit wr, input bit be,
                              input logic [23:0] addr, input logic [31:0] wd,
                              input logic [31:0] rb, input int lat,
                              input string req);
        int   cnt;
        int   n;
        int   guard;
        bit   got;
        logic [31:0] exp_rd;
        logic [31:0] rd;
        logic [7:0]  held;
        cnt    = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        exp_rd = '0;
        for (int k = 0; k < cnt; k++) begin
            int lane = be ? (cnt - 1 - k) : k;
            if (!wr) exp_rd |= 32'(rb[8*k +: 8]) << (8 * lane);
        end
        @(negedge clk);
        chk(req_ready === 1'b1, "R7", "ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_size = sz; req_write = wr; req_big_end = be;
        req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(bc_valid === 1'b1, "R7", "byte cycle after accept", 32'(bc_valid), 32'd1);
        n = 0; guard = 0; got = 1'b0; rd = '0;
        while (!got && guard < 200) begin
            if (rsp_done) begin
                got = 1'b1;
                rd  = rsp_rdata;
            end else if (bc_valid && n < 4) begin
                int lane = be ? (cnt - 1 - n) : n;
                chk(req_ready === 1'b0, "R7", "ready low while busy", 32'(req_ready), 32'd0);
                chk(bc_addr === addr, "R4", "byte cycle address", 32'(bc_addr), 32'(addr));
                chk(bc_write === wr, "R8", "byte cycle direction", 32'(bc_write), 32'(wr));
                if (wr) begin
                    chk(bc_wbyte === wd[8*lane +: 8], req, $sformatf("write byte %0d", n),
                        32'(bc_wbyte), 32'(wd[8*lane +: 8]));
                end
                held = bc_wbyte;
                for (int w = 0; w < lat; w++) begin
                    @(negedge clk);
                    guard++;
                    chk(bc_valid === 1'b1 && bc_wbyte === held, "R8", "byte held while waiting",
                        32'(bc_wbyte), 32'(held));
                end
                bc_done  = 1'b1;
                bc_rword = {rb[8*n +: 8], 8'h5A ^ 8'(n * 37)};
                @(negedge clk);
                bc_done  = 1'b0;
                bc_rword = 16'hFFFF;
                n++;
            end else begin
                @(negedge clk);
                guard++;
            end
        end
        chk(got, "R7", "completion seen", 32'(got), 32'd1);
        chk(n == cnt, "R1", "byte cycle count", 32'(n), 32'(cnt));
        chk(rd === exp_rd, wr ? "R7" : "R6", "completion data", rd, exp_rd);
        @(negedge clk);
        chk(rsp_done === 1'b0, "R7", "done is one cycle", 32'(rsp_done), 32'd0);
        chk(req_ready === 1'b1 && bc_valid === 1'b0, "R7", "idle after done",
            32'({req_ready, bc_valid}), 32'b10);
    endtask

    task automatic test_reset_state();
        chk(req_ready === 1'b1, "R9", "ready after reset", 32'(req_ready), 32'd1);
        chk(bc_valid === 1'b0, "R9", "no byte cycle after reset", 32'(bc_valid), 32'd0);
        chk(rsp_done === 1'b0, "R9", "no done after reset", 32'(rsp_done), 32'd0);
    endtask

    // R9: abort a read partway and check nothing survives into the next one
    task automatic test_reset_abort();
        @(negedge clk);
        req_valid = 1'b1; req_size = 2'd2; req_write = 1'b0; req_big_end = 1'b0;
        req_addr = 24'h00_0123; req_wdata = '0;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 2; k++) begin
            bc_done = 1'b1; bc_rword = 16'hFF00;
            @(negedge clk);
            bc_done = 1'b0;
        end
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(req_ready === 1'b1 && bc_valid === 1'b0 && rsp_done === 1'b0, "R9",
            "idle after mid-request reset", 32'({req_ready, bc_valid, rsp_done}), 32'b100);
        run_access(2'd1, 1'b0, 1'b0, 24'h00_0123, 32'h0, 32'h0000_0201, 0, "R9");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_size = '0;
        req_write = 1'b0; req_big_end = 1'b0; req_wdata = '0;
        bc_rword = 16'hFFFF; bc_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset_state();
        run_access(2'd2, 1'b1, 1'b1, 24'hA0_0010, 32'h1122_3344, 32'h0, 0, "R2");
        run_access(2'd2, 1'b1, 1'b0, 24'hA0_0010, 32'h1122_3344, 32'h0, 0, "R3");
        run_access(2'd1, 1'b1, 1'b1, 24'h00_4000, 32'hDEAD_BEEF, 32'h0, 1, "R2");
        run_access(2'd1, 1'b1, 1'b0, 24'h00_4000, 32'hDEAD_BEEF, 32'h0, 0, "R3");
        run_access(2'd0, 1'b1, 1'b1, 24'h12_3456, 32'hDEAD_BEEF, 32'h0, 0, "R1");
        run_access(2'd2, 1'b0, 1'b1, 24'h00_0200, 32'h0, 32'hD4C3_B2A1, 0, "R6");
        run_access(2'd2, 1'b0, 1'b0, 24'h00_0200, 32'h0, 32'hD4C3_B2A1, 2, "R5");
        run_access(2'd1, 1'b0, 1'b1, 24'h00_0300, 32'h0, 32'h0000_6B5A, 0, "R6");
        run_access(2'd1, 1'b0, 1'b0, 24'h00_0300, 32'h0, 32'h0000_6B5A, 0, "R6");
        run_access(2'd0, 1'b0, 1'b0, 24'h00_0301, 32'h0, 32'h0000_007E, 3, "R5");
        run_access(2'd3, 1'b1, 1'b1, 24'h7F_FFFF, 32'hCAFE_F00D, 32'h0, 0, "R1");
        run_access(2'd2, 1'b1, 1'b0, 24'h01_0000, 32'h0102_0304, 32'h0, 4, "R8");
        test_reset_abort();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule